// File: doc/BRIEF.md
# Busy-Pulse Width Classifier and Program Counter

This block watches the active-low ready/busy line of a single flash die and times each low interval in microsecond units. The die holds the line low during any read, program or erase. The three operations differ in length, so the block keeps only the low intervals whose length falls inside a programmable window. That window is set to the page-program duration, which excludes short reads and long erases. The running count, and the page total derived from it through a plane multiplier, are visible on output ports at all times.

The count is also shipped to a master over an 8N1 serial line. A report goes out on a programmable period, and that period restarts whenever a busy interval ends. A single report also goes out once the line has stayed idle for a programmable quiet time. A clear input zeroes the count and the timers.

Top module: `busy_pulse_counter`

## Requirements
- R1: The raw line is synchronised through two flops and then filtered. A level change reaches the measurement only after it has held for FILT_LEN consecutive synchronised samples, so a low lasting fewer than FILT_LEN clocks is ignored.
- R2: The width of a low interval is floor(L / CLK_PER_US) microseconds, where L is its length in clocks. The interval is counted when it ends, if and only if win_lo_i <= width <= win_hi_i. Both bounds are inclusive.
- R3: Intervals shorter than win_lo_i (reads) and longer than win_hi_i (erases) leave count_o unchanged.
- R4: The width saturates at 2^TIME_W-1 and never wraps. A very long low is therefore judged against the window at the saturated value.
- R5: pages_o always equals count_o multiplied by mult_i (1 for single-plane, 2 for two-plane programming).
- R6: One clock after clear_i is high, count_o is 0. A low interval in progress during clear_i is discarded. After reset, count_o is 0 and tx_o is high.
- R7: A low already present when reset is released is not counted when it ends.
- R8: With period_i non-zero, a report is requested every period_i microseconds. The period timer restarts when any busy interval ends. period_i = 0 disables periodic reports.
- R9: With quiet_i non-zero, exactly one report is requested after the line has been high for quiet_i microseconds. The next low re-arms this report. quiet_i = 0 disables it.
- R10: A report frame is six 8N1 bytes, each sent LSB first with BAUD_DIV clocks per bit, back to back. The first byte is 0xA5. The next four bytes are count_o, most significant byte first, captured when the frame starts. The last byte is the sum modulo 256 of those four count bytes. tx_o idles high.
- R11: count_o only ever steps by +1, on the clock after the filtered line returns high, or drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of count and timers |
| busy_ni | input | 1 | Raw ready/busy line, low while busy |
| win_lo_i | input | TIME_W | Lower window bound, microseconds |
| win_hi_i | input | TIME_W | Upper window bound, microseconds |
| period_i | input | TMR_W | Report period in microseconds, 0 disables |
| quiet_i | input | TMR_W | Idle time before the quiet report, 0 disables |
| mult_i | input | MULT_W | Pages per counted interval |
| count_o | output | 32 | Counted program intervals |
| pages_o | output | 32+MULT_W | count_o times mult_i |
| tx_o | output | 1 | Serial report stream |

## Verification
The classifier is driven with low intervals of 5, 19, 20, 40, 60, 61 and 200 microseconds. These separate the two inclusive window edges from their off-by-one neighbours and from read- and erase-length intervals. A 2-clock glitch checks the filter. A 300-microsecond low with an 8-bit width checks that the width saturates: if it wrapped, the width would land inside the window. Serial frames are decoded and matched against the counts expected from quiet-time and periodic triggers. The arrival time of a periodic frame, measured after an intervening pulse, shows whether the period timer was restarted. Clears during a pulse and a reset released with the line held low check that interrupted intervals are dropped.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int CNT_W       = 32;
  localparam int FRAME_BYTES = 6;
  localparam logic [7:0] SYNC_BYTE = 8'hA5;

  function automatic logic [7:0] frame_sum(input logic [CNT_W-1:0] c);
    return c[31:24] + c[23:16] + c[15:8] + c[7:0];
  endfunction
endpackage

// File: rtl/bpc_line_filter.sv
module bpc_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [1:0] sync_q;
  logic       line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], line_i};
  end

  generate
    if (FILT_LEN < 2) begin : g_nofilt
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) line_q <= 1'b0;
        else         line_q <= sync_q[1];
      end
    end else begin : g_filt
      logic [FILT_LEN-1:0] hist_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hist_q <= '0;
          line_q <= 1'b0;
        end else begin
          hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
          if (&hist_q)       line_q <= 1'b1;
          else if (~|hist_q) line_q <= 1'b0;
        end
      end
    end
  endgenerate

  assign line_o = line_q;
endmodule

// File: rtl/bpc_pulse_meter.sv
module bpc_pulse_meter #(
  parameter int CLK_PER_US = 250,
  parameter int TIME_W     = 16,
  parameter int CNT_W      = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              line_i,
  input  logic [TIME_W-1:0] win_lo_i,
  input  logic [TIME_W-1:0] win_hi_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              pulse_end_o
);
  localparam int PS_W = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PS_W-1:0]   PS_LAST = PS_W'(CLK_PER_US - 1);
  localparam logic [TIME_W-1:0] W_MAX   = '1;

  logic              prev_q, in_pulse_q;
  logic [PS_W-1:0]   presc_q;
  logic [TIME_W-1:0] width_q;
  logic [CNT_W-1:0]  count_q;
  logic              fall, rise, in_win;

  assign fall   = prev_q & ~line_i;
  assign rise   = ~prev_q & line_i;
  assign in_win = (width_q >= win_lo_i) && (width_q <= win_hi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= 1'b0;
      in_pulse_q <= 1'b0;
      presc_q    <= '0;
      width_q    <= '0;
      count_q    <= '0;
    end else begin
      prev_q <= line_i;
      if (clear_i) begin
        in_pulse_q <= 1'b0;
        presc_q    <= '0;
        width_q    <= '0;
        count_q    <= '0;
      end else if (fall) begin
        in_pulse_q <= 1'b1;
        presc_q    <= PS_W'(1);   // fall cycle is the first low clock
        width_q    <= '0;
      end else if (rise) begin
        in_pulse_q <= 1'b0;
        if (in_pulse_q && in_win) count_q <= count_q + 1'b1;
      end else if (!line_i && in_pulse_q) begin
        if (presc_q == PS_LAST) begin
          presc_q <= '0;
          if (width_q != W_MAX) width_q <= width_q + 1'b1;
        end else begin
          presc_q <= presc_q + 1'b1;
        end
      end
    end
  end

  assign count_o     = count_q;
  assign pulse_end_o = rise & in_pulse_q;
endmodule

// File: rtl/bpc_report_timer.sv
module bpc_report_timer #(
  parameter int CLK_PER_US = 250,
  parameter int TMR_W      = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             line_i,
  input  logic             pulse_end_i,
  input  logic [TMR_W-1:0] period_i,
  input  logic [TMR_W-1:0] quiet_i,
  output logic             req_o
);
  localparam int PS_W = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(CLK_PER_US - 1);

  logic [PS_W-1:0]  presc_q;
  logic [TMR_W-1:0] per_q, idle_q;
  logic             qdone_q, req_q, tick;
  logic [TMR_W:0]   per_nx, idle_nx;

  assign tick    = (presc_q == PS_LAST);
  assign per_nx  = {1'b0, per_q} + 1'b1;
  assign idle_nx = {1'b0, idle_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      per_q   <= '0;
      idle_q  <= '0;
      qdone_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q   <= 1'b0;
      presc_q <= tick ? '0 : presc_q + 1'b1;
      if (clear_i) begin
        per_q   <= '0;
        idle_q  <= '0;
        qdone_q <= 1'b0;
      end else begin
        if (period_i == '0 || pulse_end_i) begin
          per_q <= '0;
        end else if (tick) begin
          if (per_nx >= {1'b0, period_i}) begin
            per_q <= '0;
            req_q <= 1'b1;
          end else begin
            per_q <= per_nx[TMR_W-1:0];
          end
        end
        if (!line_i) begin
          idle_q  <= '0;
          qdone_q <= 1'b0;
        end else if (tick && !qdone_q && quiet_i != '0) begin
          if (idle_nx >= {1'b0, quiet_i}) begin
            qdone_q <= 1'b1;
            req_q   <= 1'b1;
          end else begin
            idle_q <= idle_nx[TMR_W-1:0];
          end
        end
      end
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/bpc_uart_tx.sv
module bpc_uart_tx
  import bpc_pkg::*;
#(
  parameter int BAUD_DIV = 2170
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             tx_o,
  output logic             busy_o
);
  localparam int BD_W = (BAUD_DIV > 2) ? $clog2(BAUD_DIV) : 1;
  localparam logic [BD_W-1:0] BD_LAST = BD_W'(BAUD_DIV - 1);
  localparam int REST_W = (FRAME_BYTES - 1) * 8;

  logic              pend_q, busy_q, start;
  logic [REST_W-1:0] rest_q;
  logic [9:0]        sh_q;
  logic [3:0]        bit_q;
  logic [2:0]        byte_q;
  logic [BD_W-1:0]   baud_q;

  assign start = pend_q & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      rest_q <= '0;
      sh_q   <= '1;
      bit_q  <= '0;
      byte_q <= '0;
      baud_q <= '0;
    end else begin
      if (req_i)      pend_q <= 1'b1;
      else if (start) pend_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        rest_q <= {count_i, frame_sum(count_i)};
        sh_q   <= {1'b1, SYNC_BYTE, 1'b0};
        bit_q  <= '0;
        byte_q <= '0;
        baud_q <= '0;
      end else if (busy_q) begin
        if (baud_q == BD_LAST) begin
          baud_q <= '0;
          if (bit_q == 4'd9) begin
            bit_q <= '0;
            if (byte_q == 3'(FRAME_BYTES - 1)) begin
              busy_q <= 1'b0;
            end else begin
              byte_q <= byte_q + 1'b1;
              sh_q   <= {1'b1, rest_q[REST_W-1 -: 8], 1'b0};
              rest_q <= rest_q << 8;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {1'b1, sh_q[9:1]};
          end
        end else begin
          baud_q <= baud_q + 1'b1;
        end
      end
    end
  end

  assign tx_o   = sh_q[0];
  assign busy_o = busy_q;
endmodule

// File: rtl/busy_pulse_counter.sv
module busy_pulse_counter
  import bpc_pkg::*;
#(
  parameter int CLK_PER_US = 250,
  parameter int BAUD_DIV   = 2170,
  parameter int FILT_LEN   = 3,
  parameter int TIME_W     = 16,
  parameter int TMR_W      = 32,
  parameter int MULT_W     = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    busy_ni,
  input  logic [TIME_W-1:0]       win_lo_i,
  input  logic [TIME_W-1:0]       win_hi_i,
  input  logic [TMR_W-1:0]        period_i,
  input  logic [TMR_W-1:0]        quiet_i,
  input  logic [MULT_W-1:0]       mult_i,
  output logic [CNT_W-1:0]        count_o,
  output logic [CNT_W+MULT_W-1:0] pages_o,
  output logic                    tx_o
);
  localparam int PG_W = CNT_W + MULT_W;

  logic line_filt, pulse_end, report_req, frame_busy;

  bpc_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i, .rst_ni, .line_i(busy_ni), .line_o(line_filt)
  );

  bpc_pulse_meter #(.CLK_PER_US(CLK_PER_US), .TIME_W(TIME_W), .CNT_W(CNT_W)) u_meter (
    .clk_i, .rst_ni, .clear_i, .line_i(line_filt),
    .win_lo_i, .win_hi_i, .count_o, .pulse_end_o(pulse_end)
  );

  bpc_report_timer #(.CLK_PER_US(CLK_PER_US), .TMR_W(TMR_W)) u_tmr (
    .clk_i, .rst_ni, .clear_i, .line_i(line_filt), .pulse_end_i(pulse_end),
    .period_i, .quiet_i, .req_o(report_req)
  );

  bpc_uart_tx #(.BAUD_DIV(BAUD_DIV)) u_tx (
    .clk_i, .rst_ni, .req_i(report_req), .count_i(count_o),
    .tx_o, .busy_o(frame_busy)
  );

  assign pages_o = PG_W'(count_o) * PG_W'(mult_i);
endmodule

// File: rtl/bpc_checker.sv
module bpc_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        clear_i,
  input logic [31:0] count_o,
  input logic        tx_o,
  input logic        line_filt,
  input logic        frame_busy
);
  // R11
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 32'd1 || count_o == 32'd0));

  // R11
  incr_on_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == $past(count_o) + 32'd1) |-> ($past(line_filt) && !$past(line_filt, 2)));

  // R6
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clear_i) |-> (count_o == 32'd0));

  // R10
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_busy |-> tx_o);

  // R10
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_busy) |-> !tx_o);
endmodule

bind busy_pulse_counter bpc_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .count_o(count_o),
  .tx_o(tx_o), .line_filt(line_filt), .frame_busy(frame_busy)
);

// File: tb/busy_pulse_counter_test.sv
module busy_pulse_counter_test;
  localparam int CPU  = 4;
  localparam int BAUD = 8;
  localparam int TW   = 8;
  localparam int TMW  = 16;

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0, busy_n = 1'b1;
  logic [TW-1:0]  win_lo = 8'd20, win_hi = 8'd60;
  logic [TMW-1:0] period = '0, quiet = 16'd100;
  logic [1:0]     mult = 2'd1;
  logic [31:0]    count;
  logic [33:0]    pages;
  logic           tx;

  int vectors = 0, errors = 0, cyc = 0, last_start = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  busy_pulse_counter #(.CLK_PER_US(CPU), .BAUD_DIV(BAUD), .FILT_LEN(3),
                       .TIME_W(TW), .TMR_W(TMW), .MULT_W(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .busy_ni(busy_n),
    .win_lo_i(win_lo), .win_hi_i(win_hi), .period_i(period), .quiet_i(quiet),
    .mult_i(mult), .count_o(count), .pages_o(pages), .tx_o(tx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int low_cyc, input int gap);
    @(negedge clk) busy_n = 1'b0;
    repeat (low_cyc) @(negedge clk);
    busy_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: decode frames, compare against scoreboard
  initial begin
    logic [7:0] fb [6];
    int nb = 0;
    forever begin
      @(negedge clk);
      if (rst_n && tx == 1'b0) begin
        if (nb == 0) last_start = cyc;
        repeat (BAUD / 2) @(negedge clk);
        for (int b = 0; b < 8; b++) begin
          repeat (BAUD) @(negedge clk);
          fb[nb][b] = tx;
        end
        repeat (BAUD) @(negedge clk);
        nb++;
        if (nb == 6) begin
          logic [31:0] c, e;
          nb = 0;
          c = {fb[1], fb[2], fb[3], fb[4]};
          if (exp_q.size() == 0) begin
            vectors++; errors++;
            $display("FAIL R9/R8 unexpected frame: actual count %0h expected none", c);
          end else begin
            e = exp_q.pop_front();
            chk("R10 sync byte", 64'(fb[0]), 64'h A5);
            chk("R10 count field", 64'(c), 64'(e));
            chk("R10 checksum", 64'(fb[5]), 64'(8'(e[31:24] + e[23:16] + e[15:8] + e[7:0])));
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int t_end;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 reset count", 64'(count), 64'd0);
    chk("R6 reset pages", 64'(pages), 64'd0);
    chk("R6 reset tx idle", 64'(tx), 64'd1);
    exp_q.push_back(32'd0);          // R9 quiet report after reset
    rst_n = 1'b1;
    drain();

    pulse(22, 120);    chk("R3 read 5us", 64'(count), 64'd0);
    pulse(78, 120);    chk("R2 19us below lo", 64'(count), 64'd0);
    pulse(82, 120);    chk("R2 20us lo inclusive", 64'(count), 64'd1);
    pulse(242, 120);   chk("R2 60us hi inclusive", 64'(count), 64'd2);
    pulse(246, 120);   chk("R2 61us above hi", 64'(count), 64'd2);
    pulse(2, 120);     chk("R1 glitch ignored", 64'(count), 64'd2);
    pulse(162, 120);   chk("R2 40us inside", 64'(count), 64'd3);
    pulse(800, 20);    chk("R3 erase 200us", 64'(count), 64'd3);
    exp_q.push_back(32'd3);          // R9 re-armed by the pulses
    drain();
    repeat (1000) @(negedge clk);    // R9 no second quiet frame

    chk("R5 pages x1", 64'(pages), 64'd3);
    mult = 2'd2; @(negedge clk);
    chk("R5 pages x2", 64'(pages), 64'd6);
    mult = 2'd1;

    // R8 periodic report, timer restart at pulse end
    quiet = '0;
    period = 16'd200;
    exp_q.push_back(32'd3);
    drain();
    repeat (20) @(negedge clk);
    pulse(162, 0);
    t_end = cyc;
    exp_q.push_back(32'd4);
    drain();
    period = '0;
    vectors++;
    if (last_start - t_end < 796 || last_start - t_end > 830) begin
      errors++;
      $display("FAIL R8 period restart: actual delay %0d expected 796..830", last_start - t_end);
    end

    // R6 clear, including a pulse in progress
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    chk("R6 clear count", 64'(count), 64'd0);
    chk("R6 clear pages", 64'(pages), 64'd0);
    @(negedge clk) busy_n = 1'b0;
    repeat (40) @(negedge clk);
    clear = 1'b1;
    @(negedge clk) clear = 1'b0;
    repeat (121) @(negedge clk);
    busy_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R6 pulse across clear dropped", 64'(count), 64'd0);
    pulse(162, 20);  chk("R2 count after clear", 64'(count), 64'd1);

    // R4 300us saturates at 255, wrap would give 44 (in window)
    pulse(1202, 20); chk("R4 saturated width", 64'(count), 64'd1);

    // R7 low across reset
    @(negedge clk) busy_n = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6 count in reset", 64'(count), 64'd0);
    rst_n = 1'b1;
    repeat (162) @(negedge clk);
    busy_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R7 pulse at reset dropped", 64'(count), 64'd0);
    pulse(82, 20);   chk("R2 count after reset", 64'(count), 64'd1);

    repeat (2000) @(negedge clk);
    chk("R10 scoreboard empty", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule